// File: doc/BRIEF.md
# Double-Buffered 16-bit PWM Generator

This block produces one pulse-width-modulated output from a CPU clock. A 3-bit prescaler field selects an internal tick rate, from the clock divided by 2 up to the clock divided by 128. A 16-bit counter advances once per tick and wraps at a programmed cycle value. The output goes high at the start of every cycle and drops when the counter reaches a programmed duty value.

Software configures the block through a byte-wide, write-only register port. The control byte holds the enable bit, the prescaler field, an interrupt mask and a flag-clear strobe. Cycle and duty values are each written as two bytes. A new 16-bit value is armed only once both of its bytes have been written, in either order. It takes effect at the next counter wrap, so the cycle in progress is never disturbed. Re-enabling the block loads the byte registers straight into the active registers, and the prescaler field acts at once. The single interrupt output is a latched flag. Each counter wrap sets it while the mask is on, and a clear strobe resets it.

Top module: `pwm16`

## Requirements
- R1: The tick period is 2^(PS+1) clocks for a PS field value of 0 to 6, and a PS value of 7 gives 128 clocks. PS occupies bits 3:1 of the control byte, which is written at address 0.
- R2: Bit 0 of the control byte enables the block. While the block is disabled, the counter is held at zero and pwmOut is low.
- R3: With the block enabled, the counter steps once per tick and wraps to zero after it reaches the active cycle value C. Each PWM period is therefore C+1 ticks long.
- R4: When 0 < D < C, pwmOut is high for the first D ticks of each period and low for the rest, where D is the active duty value.
- R5: When D is nonzero and C <= D, pwmOut stays high continuously.
- R6: When D is zero, pwmOut stays low. Both active values reset to zero, so enabling the block before any write gives a permanently low output.
- R7: The cycle bytes are written at addresses 1 (low) and 2 (high), and the duty bytes at addresses 3 (low) and 4 (high). Writing only one byte of a pair has no effect while the block runs. Once both bytes of a pair have been written, in either order, the new value is armed.
- R8: An armed value never changes the period in progress. It becomes active at the next counter wrap.
- R9: When the enable bit goes from 0 to 1, the current cycle and duty byte registers are copied into the active values, whether or not both bytes of each pair were written.
- R10: Writing a new PS value while the block is enabled changes the tick rate immediately, without waiting for a wrap.
- R11: Bit 4 of the control byte masks the interrupt. Each counter wrap sets the irq flag while the mask bit is 1, and a wrap with the mask bit at 0 leaves the flag unchanged. Writing the control byte with bit 5 set clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| pwmOut | output | 1 | PWM output |
| irq | output | 1 | Latched, maskable wrap interrupt |

## Verification
The bench sweeps every combination of cycle values 0 to 5 and duty values 0 to 6 at the fastest tick. It counts high clocks over whole periods, which separates the zero-duty, partial-duty and always-high regions, including the boundary where the cycle equals the duty. A sweep of all eight prescaler codes with a fixed waveform tells the divide ratios apart and shows that code 7 matches code 6.

Staged writes are tried in four patterns:
- a single byte alone,
- both bytes in low-then-high order,
- both bytes in high-then-low order,
- a pair completed just after a period has started.

The high width of that period and of the one after it separate a deferred update from an immediate one. Further runs cover:
- re-enabling after partial writes,
- a prescaler change while the block runs,
- the interrupt with the mask off, with the mask on, and after a clear.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CYC_LO = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CYC_HI = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DUT_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DUT_HI = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic            run;
    logic [PS_W-1:0] ps;
    logic            loadCycle;
    logic            loadDuty;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm16_ctrl.sv
module pwm16_ctrl
  import pwm16_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                ovf,
  output pwmStrobe_t          strb,
  output logic [2*DATA_W-1:0] cycleShadow,
  output logic [2*DATA_W-1:0] dutyShadow,
  output logic                irq
);
  logic            en, enPrev, mask, flagR;
  logic [PS_W-1:0] ps;
  logic [DATA_W-1:0] cycLo, cycHi, dutLo, dutHi;
  logic cycLoW, cycHiW, dutLoW, dutHiW;
  logic enRise;

  assign enRise = en & ~enPrev;

  always_comb begin
    strb.run       = en;
    strb.ps        = ps;
    strb.loadCycle = enRise | (ovf & cycLoW & cycHiW);
    strb.loadDuty  = enRise | (ovf & dutLoW & dutHiW);
  end

  assign cycleShadow = {cycHi, cycLo};
  assign dutyShadow  = {dutHi, dutLo};
  assign irq         = flagR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en <= 1'b0; enPrev <= 1'b0; mask <= 1'b0; flagR <= 1'b0;
      ps <= '0;
      cycLo <= '0; cycHi <= '0; dutLo <= '0; dutHi <= '0;
      cycLoW <= 1'b0; cycHiW <= 1'b0; dutLoW <= 1'b0; dutHiW <= 1'b0;
    end else begin
      enPrev <= en;
      if (strb.loadCycle) begin
        cycLoW <= 1'b0;
        cycHiW <= 1'b0;
      end
      if (strb.loadDuty) begin
        dutLoW <= 1'b0;
        dutHiW <= 1'b0;
      end
      if (wrEn) begin
        case (wrAddr)
          ADDR_CTRL: begin
            en   <= wrData[0];
            ps   <= wrData[3:1];
            mask <= wrData[4];
            if (wrData[5]) flagR <= 1'b0;
          end
          ADDR_CYC_LO: begin cycLo <= wrData; cycLoW <= 1'b1; end
          ADDR_CYC_HI: begin cycHi <= wrData; cycHiW <= 1'b1; end
          ADDR_DUT_LO: begin dutLo <= wrData; dutLoW <= 1'b1; end
          ADDR_DUT_HI: begin dutHi <= wrData; dutHiW <= 1'b1; end
          default: ;
        endcase
      end
      if (ovf && mask) flagR <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm16_dp.sv
module pwm16_dp
  import pwm16_pkg::*;
#(
  parameter int CNT_W = 2 * DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strb,
  input  logic [CNT_W-1:0] cycleShadow,
  input  logic [CNT_W-1:0] dutyShadow,
  output logic             pwmOut,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] actCycle,
  output logic [CNT_W-1:0] actDuty
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] preCnt, tickMask;
  logic [PS_W-1:0]  psEff;
  logic             tick;

  always_comb begin
    psEff = (strb.ps == PS_W'(PRE_W)) ? PS_W'(PRE_W - 1) : strb.ps;
    for (int i = 0; i < PRE_W; i++) tickMask[i] = (i <= int'(psEff));
  end

  assign tick   = ((preCnt & tickMask) == tickMask);
  assign ovf    = strb.run & tick & (cnt == actCycle);
  assign pwmOut = strb.run & (actDuty != '0) &
                  ((cnt < actDuty) | (actCycle <= actDuty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      cnt      <= '0;
      actCycle <= '0;
      actDuty  <= '0;
    end else begin
      if (!strb.run) begin
        preCnt <= '0;
        cnt    <= '0;
      end else begin
        preCnt <= preCnt + 1'b1;
        if (tick) cnt <= ovf ? '0 : cnt + 1'b1;
      end
      if (strb.loadCycle) actCycle <= cycleShadow;
      if (strb.loadDuty)  actDuty  <= dutyShadow;
    end
  end
endmodule

// File: rtl/pwm16.sv
module pwm16
  import pwm16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pwmOut,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  pwmStrobe_t       strb;
  logic             ovf;
  logic [CNT_W-1:0] cycleShadow, dutyShadow, cnt, actCycle, actDuty;

  pwm16_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ovf(ovf), .strb(strb), .cycleShadow(cycleShadow),
    .dutyShadow(dutyShadow), .irq(irq)
  );

  pwm16_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cycleShadow(cycleShadow),
    .dutyShadow(dutyShadow), .pwmOut(pwmOut), .ovf(ovf), .cnt(cnt),
    .actCycle(actCycle), .actDuty(actDuty)
  );
endmodule

// File: rtl/pwm16_checker.sv
module pwm16_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwmOut,
  input logic             irq,
  input logic             run,
  input logic             loadCycle,
  input logic             ovf,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] actCycle,
  input logic [CNT_W-1:0] actDuty
);
  assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> cnt == '0);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(ovf) && cnt != $past(cnt)) |->
      cnt == $past(cnt) + 1'b1);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> cnt == '0);

  assert_cycle_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loadCycle |=> $stable(actCycle));

  assert_zero_duty_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (actDuty == '0) |-> !pwmOut);

  assert_irq_from_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(ovf));
endmodule

bind pwm16 pwm16_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .irq(irq),
  .run(strb.run), .loadCycle(strb.loadCycle), .ovf(ovf), .cnt(cnt),
  .actCycle(actCycle), .actDuty(actDuty)
);

// File: tb/pwm16_test.sv
`timescale 1ns/1ps
module pwm16_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut, irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwm16 uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input int en, input int ps,
                                     input int msk, input int clr);
    return 8'((clr << 5) | (msk << 4) | (ps << 1) | en);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countHigh(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
  endtask

  task automatic config16(input int c, input int d, input int ps);
    wrReg(3'd0, ctl(0, 0, 0, 0));
    wrReg(3'd1, 8'(c)); wrReg(3'd2, 8'(c >> 8));
    wrReg(3'd3, 8'(d)); wrReg(3'd4, 8'(d >> 8));
    wrReg(3'd0, ctl(1, ps, 0, 0));
  endtask

  task automatic waitRise();
    logic prev;
    prev = pwmOut;
    forever begin
      @(negedge clk);
      if (pwmOut && !prev) break;
      prev = pwmOut;
    end
  endtask

  task automatic waitFall();
    while (pwmOut) @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi, per, expHi, div;
    realtime t0;
    bit seen;

    idle(3);
    check("R6 reset pwmOut", int'(pwmOut), 0);
    check("R11 reset irq", int'(irq), 0);
    rstN = 1'b1;
    idle(2);

    // R6: enabled with default zero values
    wrReg(3'd0, ctl(1, 0, 0, 0));
    countHigh(200, hi);
    check("R6 defaults low", hi, 0);

    // R3 R4 R5 R6: sweep cycle and duty at tick = 2 clocks
    for (int c = 0; c <= 5; c++) begin
      for (int d = 0; d <= 6; d++) begin
        per = 2 * (c + 1);
        expHi = (d == 0) ? 0 : ((d >= c) ? per : 2 * d);
        config16(c, d, 0);
        idle(2 * per + 6);
        countHigh(3 * per, hi);
        check($sformatf("R4 R5 sweep c=%0d d=%0d", c, d), hi, 3 * expHi);
      end
    end

    // R1: prescaler codes, cycle 3, duty 2
    for (int p = 0; p <= 7; p++) begin
      div = (p == 7) ? 128 : (2 << p);
      per = 4 * div;
      config16(3, 2, p);
      idle(2 * per + 4);
      countHigh(2 * per, hi);
      check($sformatf("R1 prescale ps=%0d", p), hi, per);
    end

    // R10: prescaler change while running
    config16(3, 2, 7);
    idle(600);
    wrReg(3'd0, ctl(1, 0, 0, 0));
    idle(20);
    countHigh(16, hi);
    check("R10 immediate prescale", hi, 8);

    // R2: disabled output low
    wrReg(3'd0, ctl(0, 0, 0, 0));
    countHigh(50, hi);
    check("R2 disabled low", hi, 0);

    // R8: pair completed inside a running period
    config16(9, 4, 0);
    idle(50);
    waitRise();
    t0 = $realtime;
    wrReg(3'd3, 8'd6);
    wrReg(3'd4, 8'd0);
    waitFall();
    check("R8 current period kept", int'(($realtime - t0) / 4.0), 8);
    waitRise();
    t0 = $realtime;
    waitFall();
    check("R8 next period new duty", int'(($realtime - t0) / 4.0), 12);

    // R7: single duty byte ignored, then low-then-high arms
    wrReg(3'd3, 8'd2);
    idle(50);
    countHigh(60, hi);
    check("R7 duty low byte alone", hi, 36);
    wrReg(3'd4, 8'd0);
    idle(50);
    countHigh(60, hi);
    check("R7 duty lo then hi", hi, 12);

    // R7: cycle high byte alone, then high-then-low
    wrReg(3'd2, 8'd0);
    idle(50);
    countHigh(60, hi);
    check("R7 cycle high byte alone", hi, 12);
    wrReg(3'd1, 8'd14);
    idle(70);
    countHigh(90, hi);
    check("R7 cycle hi then lo", hi, 12);

    // R9: re-enable loads partial writes
    wrReg(3'd0, ctl(0, 0, 0, 0));
    wrReg(3'd1, 8'd4);
    wrReg(3'd3, 8'd3);
    wrReg(3'd0, ctl(1, 0, 0, 0));
    idle(24);
    countHigh(30, hi);
    check("R9 partial load on enable", hi, 18);

    // R11: interrupt mask, set, clear
    config16(9, 4, 3);
    idle(400);
    check("R11 masked no irq", int'(irq), 0);
    wrReg(3'd0, ctl(1, 3, 1, 0));
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check("R11 irq set on wrap", int'(seen), 1);
    wrReg(3'd0, ctl(1, 3, 1, 1));
    check("R11 irq cleared", int'(irq), 0);
    idle(170);
    check("R11 irq set again", int'(irq), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule